// File: doc/BRIEF.md
# Banked Shared Memory Arbiter

This block sits in front of a tile's local data memory and lets several requesters use it at once: two load ports and one store port of the local core, the three neighbouring tiles (north, south and east) and two data movers. The memory is divided into logical banks. Each logical bank holds several physical banks interleaved on the lowest word-address bits. Every physical bank has its own round-robin arbiter, so requests that land in different physical banks are all served in the same cycle. Requests that collide in one physical bank are served one per cycle.

A requester raises its request together with a word address, a write enable and write data. It keeps all of them steady until it sees its grant, which is combinational in the same cycle. A granted read returns its data on the same requester's lane one cycle later, marked by a valid strobe. The default sizes are a scaled-down version of the full arrangement: four logical banks of two physical banks each, 256 words of 32 bits per physical bank. The full 64 KB arrangement is reached by raising the row-count parameter.

Top module: `banked_mem_arbiter`

## Requirements
- R1: The word address has ADDR_W = 11 bits by default. Bits [10:9] select the logical bank and bit [0] selects the physical bank inside it, giving physical bank number = 2*bits[10:9] + bit[0]. Bits [8:1] select the row. Two requests that differ only in bit 0 are served in parallel. Two requests with equal bits [10:9] and bit 0 collide.
- R2: A physical bank grants at most one requester per cycle. A read and a write to the same physical bank in the same cycle are granted in different cycles.
- R3: When every requesting port targets a different physical bank, all of them are granted in the same cycle. A bank with at least one request always grants one.
- R4: Each bank's round-robin pointer starts at requester 0 after reset. Among the contenders for a bank, the first at or after the pointer (scanning upward with wrap) wins, and the pointer then moves to one past the winner.
- R5: A request held steady is granted within NUM_REQ cycles, so it never waits NUM_REQ cycles or more.
- R6: A granted read produces rvalid on that requester's lane exactly one cycle after the grant, with the addressed word on its rdata lane. No rvalid appears without such a grant.
- R7: A granted write stores its data at the addressed word. A later read returns that data. A write never produces rvalid.
- R8: After reset, with no requests, gnt_o and rvalid_o are all zero.
- R9: A grant is only given to a port whose request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_REQ | Request per port |
| addr_i | input | NUM_REQ*ADDR_W | Word address per port, port i in slice i |
| we_i | input | NUM_REQ | Write enable per port |
| wdata_i | input | NUM_REQ*DATA_W | Write data per port |
| gnt_o | output | NUM_REQ | Same-cycle grant per port |
| rvalid_o | output | NUM_REQ | Read data valid, one cycle after a read grant |
| rdata_o | output | NUM_REQ*DATA_W | Read data per port |

## Verification
The wait-bound property assumes that a losing requester keeps its request, address and write enable unchanged until it is granted. If a requester moved to another bank while waiting, the round-robin guarantee would not hold. The stimulus respects this: a bench requester drops or changes its request only in the cycle after its grant. Random addresses are squeezed into a few rows and biased toward one bank, so the stimulus produces plenty of collisions and read-after-write traffic while staying within that contract.

// File: rtl/mba_pkg.sv
package mba_pkg;

   // defaults shared by the block and its bench
   localparam int DEF_NUM_REQ    = 8;
   localparam int DEF_DATA_W     = 32;
   localparam int DEF_NUM_LBANK  = 4;
   localparam int DEF_PHYS_PER   = 2;
   localparam int DEF_ROWS       = 256;

   // next index with wrap-around
   function automatic int wrap_next(input int cur, input int limit);
      return (cur + 1 >= limit) ? 0 : cur + 1;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mba_addr_split.sv
module mba_addr_split #(
   parameter int AW   = 11,
   parameter int LB_W = 2,
   parameter int PB_W = 1,
   localparam int BID_W = LB_W + PB_W,
   localparam int ROW_W = AW - LB_W - PB_W
) (
   input  logic [AW-1:0]    addr,
   output logic [BID_W-1:0] bank_id,
   output logic [ROW_W-1:0] row
);

   generate
      if (PB_W == 0) begin : g_no_interleave
         assign bank_id = addr[AW-1 -: LB_W];
         assign row     = addr[ROW_W-1:0];
      end else begin : g_interleave
         // logical bank from the top bits, physical bank from the low bits
         assign bank_id = {addr[AW-1 -: LB_W], addr[PB_W-1:0]};
         assign row     = addr[AW-LB_W-1:PB_W];
      end
   endgenerate

endmodule

// File: rtl/mba_rr_arbiter.sv
module mba_rr_arbiter #(
   parameter int N = 8,
   localparam int PW = (N > 1) ? $clog2(N) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   logic [PW-1:0] ptr_q;
   logic [PW-1:0] win_idx;
   logic          found;
   int            idx;

   always_comb begin
      gnt     = '0;
      win_idx = '0;
      found   = 1'b0;
      idx     = 0;
      for (int k = 0; k < N; k++) begin
         idx = (int'(ptr_q) + k) % N;
         if (!found && req[idx]) begin
            found    = 1'b1;
            gnt[idx] = 1'b1;
            win_idx  = PW'(idx);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (found) begin
         ptr_q <= PW'(mba_pkg::wrap_next(int'(win_idx), N));
      end
   end

   AST_ONE_GRANT_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R2

   AST_BANK_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|gnt)); // R3

endmodule

// File: rtl/mba_bank.sv
module mba_bank #(
   parameter int DW    = 32,
   parameter int ROWS  = 256,
   localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [RW-1:0] row,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] store [ROWS];

   // one access per cycle: either a write or a read
   always_ff @(posedge clk) begin
      if (en) begin
         if (we) begin
            store[row] <= wdata;
         end else begin
            rdata <= store[row];
         end
      end
   end

endmodule

// File: rtl/banked_mem_arbiter.sv
module banked_mem_arbiter #(
   parameter int NUM_REQ        = mba_pkg::DEF_NUM_REQ,
   parameter int DATA_W         = mba_pkg::DEF_DATA_W,
   parameter int NUM_LBANK      = mba_pkg::DEF_NUM_LBANK,
   parameter int PHYS_PER_LBANK = mba_pkg::DEF_PHYS_PER,
   parameter int ROWS_PER_BANK  = mba_pkg::DEF_ROWS,
   localparam int LB_W   = $clog2(NUM_LBANK),
   localparam int PB_W   = $clog2(PHYS_PER_LBANK),
   localparam int ROW_W  = $clog2(ROWS_PER_BANK),
   localparam int BID_W  = LB_W + PB_W,
   localparam int NB     = NUM_LBANK * PHYS_PER_LBANK,
   localparam int ADDR_W = BID_W + ROW_W,
   localparam int CNT_W  = $clog2(NUM_REQ) + 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_REQ-1:0]          req_i,
   input  logic [NUM_REQ*ADDR_W-1:0]   addr_i,
   input  logic [NUM_REQ-1:0]          we_i,
   input  logic [NUM_REQ*DATA_W-1:0]   wdata_i,
   output logic [NUM_REQ-1:0]          gnt_o,
   output logic [NUM_REQ-1:0]          rvalid_o,
   output logic [NUM_REQ*DATA_W-1:0]   rdata_o
);

   // elaboration-time parameter checks
   generate
      if (NUM_REQ < 2) begin : g_chk_req
         $error("NUM_REQ must be at least 2");
      end
      if (!mba_pkg::is_pow2(NUM_LBANK) || NUM_LBANK < 2) begin : g_chk_lb
         $error("NUM_LBANK must be a power of two, at least 2");
      end
      if (!mba_pkg::is_pow2(PHYS_PER_LBANK)) begin : g_chk_pb
         $error("PHYS_PER_LBANK must be a power of two");
      end
      if (!mba_pkg::is_pow2(ROWS_PER_BANK) || ROWS_PER_BANK < 2) begin : g_chk_rows
         $error("ROWS_PER_BANK must be a power of two, at least 2");
      end
   endgenerate

   logic [BID_W-1:0]            bid_a  [NUM_REQ];
   logic [ROW_W-1:0]            row_a  [NUM_REQ];
   logic [NB-1:0][NUM_REQ-1:0]  bgnt_all;
   logic [NB-1:0][DATA_W-1:0]   brdata_all;

   // address decode per requester
   generate
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_split
         mba_addr_split #(
            .AW   (ADDR_W),
            .LB_W (LB_W),
            .PB_W (PB_W)
         ) u_split (
            .addr    (addr_i[i*ADDR_W +: ADDR_W]),
            .bank_id (bid_a[i]),
            .row     (row_a[i])
         );
      end
   endgenerate

   // one arbiter and one storage array per physical bank
   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         logic [NUM_REQ-1:0] req_v;
         logic [NUM_REQ-1:0] gnt_v;
         logic               sel_we;
         logic [ROW_W-1:0]   sel_row;
         logic [DATA_W-1:0]  sel_wd;

         always_comb begin
            for (int i = 0; i < NUM_REQ; i++) begin
               req_v[i] = req_i[i] && (bid_a[i] == BID_W'(b));
            end
         end

         mba_rr_arbiter #(.N(NUM_REQ)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_v),
            .gnt   (gnt_v)
         );

         // one-hot grant selects the winning command
         always_comb begin
            sel_we  = 1'b0;
            sel_row = '0;
            sel_wd  = '0;
            for (int i = 0; i < NUM_REQ; i++) begin
               if (gnt_v[i]) begin
                  sel_we  = sel_we | we_i[i];
                  sel_row = sel_row | row_a[i];
                  sel_wd  = sel_wd | wdata_i[i*DATA_W +: DATA_W];
               end
            end
         end

         mba_bank #(.DW(DATA_W), .ROWS(ROWS_PER_BANK)) u_bank (
            .clk   (clk),
            .en    (|gnt_v),
            .we    (sel_we),
            .row   (sel_row),
            .wdata (sel_wd),
            .rdata (brdata_all[b])
         );

         assign bgnt_all[b] = gnt_v;
      end
   endgenerate

   always_comb begin
      gnt_o = '0;
      for (int b = 0; b < NB; b++) begin
         gnt_o = gnt_o | bgnt_all[b];
      end
   end

   // read return tracking and wait counting per requester
   generate
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_port
         logic             rv_q;
         logic [BID_W-1:0] rb_q;
         logic [CNT_W-1:0] wait_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rv_q   <= 1'b0;
               rb_q   <= '0;
               wait_q <= '0;
            end else begin
               rv_q <= gnt_o[i] & ~we_i[i];
               if (gnt_o[i]) begin
                  rb_q <= bid_a[i];
               end
               if (req_i[i] && !gnt_o[i]) begin
                  if (wait_q != {CNT_W{1'b1}}) begin
                     wait_q <= wait_q + 1'b1;
                  end
               end else begin
                  wait_q <= '0;
               end
            end
         end

         assign rvalid_o[i] = rv_q;
         assign rdata_o[i*DATA_W +: DATA_W] = rv_q ? brdata_all[rb_q] : '0;

         AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            int'(wait_q) < NUM_REQ); // R5

         AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
            rvalid_o[i] |-> $past(gnt_o[i] && !we_i[i])); // R6

         AST_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[i] && we_i[i]) |=> !rvalid_o[i]); // R7

         AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[i] |-> req_i[i]); // R9
      end
   endgenerate

endmodule

// File: tb/sim_banked_mem_arbiter.sv
module sim_banked_mem_arbiter;

   localparam int N  = 8;
   localparam int AW = 11;
   localparam int DW = 32;
   localparam int NB = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_i = '0;
   logic [N*AW-1:0] addr_i = '0;
   logic [N-1:0]    we_i = '0;
   logic [N*DW-1:0] wdata_i = '0;
   logic [N-1:0]    gnt_o;
   logic [N-1:0]    rvalid_o;
   logic [N*DW-1:0] rdata_o;

   banked_mem_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .we_i(we_i),
      .wdata_i(wdata_i), .gnt_o(gnt_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // requester state
   bit          act [N];
   logic [AW-1:0] baddr [N];
   bit          bwe [N];
   logic [DW-1:0] bwd [N];
   int          wt [N];
   // pending read returns
   bit          pv [N];
   bit          pk [N];
   logic [DW-1:0] pd [N];
   // reference model
   int          mptr [NB];
   logic [DW-1:0] mmem [NB][256];
   bit          mw [NB][256];
   logic [N-1:0] last_gnt;

   function automatic int bank_of(input logic [AW-1:0] a);
      return int'(a[10:9]) * 2 + int'(a[0]);
   endfunction

   function automatic int row_of(input logic [AW-1:0] a);
      return int'(a[8:1]);
   endfunction

   function automatic logic [AW-1:0] mk_addr(input int lb, input int pb, input int row);
      return {lb[1:0], row[7:0], pb[0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] actv, input logic [DW-1:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actv, expv, $time);
      end
   endtask

   task automatic set_req(input int i, input logic [AW-1:0] a, input bit w, input logic [DW-1:0] d);
      act[i] = 1'b1; baddr[i] = a; bwe[i] = w; bwd[i] = d; wt[i] = 0;
   endtask

   task automatic step();
      logic [N-1:0] eg;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         req_i[i] = act[i];
         addr_i[i*AW +: AW] = baddr[i];
         we_i[i] = bwe[i];
         wdata_i[i*DW +: DW] = bwd[i];
      end
      #4;
      for (int i = 0; i < N; i++) begin
         chk(rvalid_o[i] == pv[i], "R6 rvalid timing", DW'(rvalid_o[i]), DW'(pv[i]));
         if (pv[i] && pk[i])
            chk(rdata_o[i*DW +: DW] == pd[i], "R7 read data", rdata_o[i*DW +: DW], pd[i]);
      end
      eg = '0;
      for (int bb = 0; bb < NB; bb++) begin
         for (int k = 0; k < N; k++) begin
            int idx;
            idx = (mptr[bb] + k) % N;
            if (act[idx] && bank_of(baddr[idx]) == bb) begin
               eg[idx] = 1'b1;
               mptr[bb] = (idx + 1) % N;
               break;
            end
         end
      end
      chk(gnt_o == eg, "R4 grant pattern", DW'(gnt_o), DW'(eg));
      chk((gnt_o & ~req_i) == '0, "R9 grant without request", DW'(gnt_o), DW'(req_i));
      for (int bb = 0; bb < NB; bb++) begin
         int cnt;
         cnt = 0;
         for (int i = 0; i < N; i++)
            if (gnt_o[i] && bank_of(baddr[i]) == bb) cnt++;
         chk(cnt <= 1, "R2 grants per bank", DW'(cnt), DW'(1));
      end
      last_gnt = gnt_o;
      for (int i = 0; i < N; i++) begin
         pv[i] = 1'b0;
         if (eg[i]) begin
            if (bwe[i]) begin
               mmem[bank_of(baddr[i])][row_of(baddr[i])] = bwd[i];
               mw[bank_of(baddr[i])][row_of(baddr[i])] = 1'b1;
            end else begin
               pv[i] = 1'b1;
               pd[i] = mmem[bank_of(baddr[i])][row_of(baddr[i])];
               pk[i] = mw[bank_of(baddr[i])][row_of(baddr[i])];
            end
            act[i] = 1'b0;
            wt[i] = 0;
         end else if (act[i]) begin
            wt[i]++;
            chk(wt[i] < N, "R5 wait bound", DW'(wt[i]), DW'(N - 1));
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < N; i++) begin
         act[i] = 0; baddr[i] = '0; bwe[i] = 0; bwd[i] = '0; wt[i] = 0;
         pv[i] = 0; pk[i] = 0; pd[i] = '0;
      end
      for (int b = 0; b < NB; b++) begin
         mptr[b] = 0;
         for (int r = 0; r < 256; r++) begin mw[b][r] = 0; mmem[b][r] = '0; end
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R8: quiet after reset
      #2;
      chk(gnt_o == '0, "R8 grant after reset", DW'(gnt_o), '0);
      chk(rvalid_o == '0, "R8 rvalid after reset", DW'(rvalid_o), '0);
      step();

      // R3: all ports to distinct banks, writes
      for (int i = 0; i < N; i++)
         set_req(i, mk_addr(i / 2, i % 2, 5), 1'b1, DW'(32'hA000 + i));
      step();
      chk(last_gnt == 8'hFF, "R3 parallel grants", DW'(last_gnt), DW'(8'hFF));

      // R4: all ports to bank 0, bank 0 pointer now sits at 1
      for (int i = 0; i < N; i++)
         set_req(i, mk_addr(0, 0, 10 + i), 1'b1, DW'(32'hB000 + i));
      for (int k = 0; k < N; k++) begin
         step();
         chk(last_gnt == 8'(1 << ((1 + k) % N)), "R4 rotation order", DW'(last_gnt), DW'(1 << ((1 + k) % N)));
      end

      // R2/R7: write and read colliding in bank 3
      set_req(2, mk_addr(1, 1, 5), 1'b1, 32'h1111_2222);
      step();
      set_req(2, mk_addr(1, 1, 5), 1'b1, 32'h3333_4444);
      set_req(5, mk_addr(1, 1, 5), 1'b0, '0);
      step();
      chk(last_gnt == 8'h20, "R2 read served first", DW'(last_gnt), DW'(8'h20));
      step();
      chk(last_gnt == 8'h04, "R2 write served next", DW'(last_gnt), DW'(8'h04));
      chk(rdata_o[5*DW +: DW] == 32'h1111_2222, "R6 old data returned", rdata_o[5*DW +: DW], 32'h1111_2222);
      set_req(5, mk_addr(1, 1, 5), 1'b0, '0);
      step();
      step();
      chk(rvalid_o[5] && rdata_o[5*DW +: DW] == 32'h3333_4444, "R7 new data returned", rdata_o[5*DW +: DW], 32'h3333_4444);

      // R1: bit 0 splits a logical bank, equal bit 0 collides
      set_req(0, mk_addr(1, 0, 2), 1'b0, '0);
      set_req(1, mk_addr(1, 1, 2), 1'b0, '0);
      set_req(3, mk_addr(1, 0, 7), 1'b0, '0);
      step();
      chk(last_gnt == 8'h0A, "R1 interleave decode", DW'(last_gnt), DW'(8'h0A));
      step();
      chk(last_gnt == 8'h01, "R1 collided request", DW'(last_gnt), DW'(8'h01));
      step();

      // random traffic with collisions and reuse
      for (int c = 0; c < 4000; c++) begin
         for (int i = 0; i < N; i++) begin
            if (!act[i] && ($urandom % 2 == 0)) begin
               int bk;
               bk = ($urandom % 4 == 0) ? 0 : int'($urandom % NB);
               set_req(i, mk_addr(bk / 2, bk % 2, int'($urandom % 8)), bit'($urandom % 2), $urandom);
            end
         end
         step();
      end
      for (int i = 0; i < N; i++) act[i] = 0;
      repeat (3) step();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule